// File: doc/BRIEF.md
# Six-Line GPIO Controller with Per-Line Interrupts

This block is a small general-purpose I/O controller. Software configures it over a plain 32-bit register port with address, write strobe, write data, read strobe and read data. Each line has a direction bit and an output value, which go straight to the pad as an output-enable and a data level. Every pad input passes through a two-flop synchroniser. Its synchronised level can be read at any time, whatever the line's direction.

Every line can raise an interrupt. Per line, software chooses level or edge sensing and the active polarity, and can enable and mask the line. Edge events are held in a sticky latch until software acknowledges them by writing a one to the acknowledge register. A level request is live: it follows the pin and cannot be acknowledged away. The status register reports requests that are pending, enabled and unmasked. The OR of the status bits drives the single interrupt output.

Register word offsets: 0x00 output data, 0x04 direction, 0x08 pin level, 0x0C interrupt enable, 0x10 interrupt mask, 0x14 sense type, 0x18 polarity, 0x1C interrupt status, 0x20 acknowledge. Bit i of every register belongs to line i. Bits above line 5 read as zero.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, pad_oe and pad_out are 0, and irq is 0.
- R2: Direction (0x04) bit 1 makes the line an output: pad_oe follows the register the cycle after the write. pad_out follows output data (0x00). Both registers read back their low six bits.
- R3: Pin level (0x08) returns pad_in after two clock edges of synchronisation, for inputs and outputs alike. Writes to it are ignored.
- R4: Type bit 0 (0x14) selects level sensing. The line is pending exactly while its synchronised pin equals its polarity bit (0x18, 1 = high, 0 = low).
- R5: Type bit 1 selects edge sensing. With polarity 1 a rising edge is latched, with polarity 0 a falling edge. The latch holds after the pin returns.
- R6: A 1 written to acknowledge (0x20) clears that line's edge latch, and a 0 leaves it alone. An edge event in the same cycle as the clear wins. The register reads 0.
- R7: An acknowledge write does not clear a pending level request.
- R8: A line whose enable bit (0x0C) is 0 neither latches edges nor shows in status. Enabling it later does not reveal an edge that came while it was disabled.
- R9: Mask bit 1 (0x10) hides the line from status and irq but keeps its edge latch, so clearing the mask reveals it.
- R10: Status (0x1C) is pending AND enable AND NOT mask per line. irq is the OR of the status bits, with no extra delay.
- R11: Changing a line's polarity while it is in edge mode and its pin is steady creates no event.
- R12: Switching a line from edge to level sensing discards its edge latch.
- R13: A read returns data on reg_rdata one cycle after the read strobe, and reg_rdata holds between reads. Unmapped offsets, including any address with bits above bit 5 set, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| pad_in | input | 6 | Asynchronous pad levels |
| pad_out | output | 6 | Levels driven on the pads |
| pad_oe | output | 6 | Per-line output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The lines are driven through rising and falling pulses on single lines, and on two lines at once, under each pairing of sense type and polarity. This separates polarity handling, the edge-versus-level choice and the OR into irq. Enable, mask and acknowledge are each toggled around a latched event, so a bench can tell an event that was never latched from one that is only hidden. A polarity flip on a steady high pin, a change of sense type with a latched edge, and an acknowledge placed in the very cycle an edge lands test the ordering rules. A full behavioural model compares irq, the pad outputs and the read data every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Word index of each register (byte address bits [5:2]).
   typedef enum logic [3:0] {
      W_DOUT  = 4'd0,
      W_DIR   = 4'd1,
      W_PIN   = 4'd2,
      W_IEN   = 4'd3,
      W_IMASK = 4'd4,
      W_ITYPE = 4'd5,
      W_IPOL  = 4'd6,
      W_ISTAT = 4'd7,
      W_IACK  = 4'd8
   } gpio_word_e;

   localparam int WORD_LSB = 2;
   localparam int WORD_MSB = 5;

   // Byte address of a register word.
   function automatic int byte_addr(gpio_word_e w);
      return int'(w) << WORD_LSB;
   endfunction

endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
   parameter int WIDTH  = 6,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_line_irq.sv
module gpio_line_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic edge_mode,
   input  logic pol_high,
   input  logic enable,
   input  logic mask,
   input  logic ack,
   output logic edge_evt,
   output logic latched,
   output logic status
);

   logic pin_prev;
   logic rise, fall;
   logic lvl_active;
   logic raw_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev <= 1'b0;
      else        pin_prev <= pin_s;
   end

   // Transitions come from the pin history only, so a polarity
   // change on a steady pin cannot look like an edge.
   assign rise       = pin_s & ~pin_prev;
   assign fall       = ~pin_s & pin_prev;
   assign edge_evt   = edge_mode & enable & (pol_high ? rise : fall);
   assign lvl_active = (pin_s == pol_high);

   // A new event beats a clear in the same cycle; level mode drops the latch.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latched <= 1'b0;
      else        latched <= edge_mode & (edge_evt | (latched & ~ack));
   end

   assign raw_pend = edge_mode ? latched : lvl_active;
   assign status   = raw_pend & enable & ~mask;

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_irq_pkg::*;
#(
   parameter int N_LINES = 6,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               reg_rd,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [N_LINES-1:0] pin_s,
   input  logic [N_LINES-1:0] irq_status,
   output logic [N_LINES-1:0] cfg_dout,
   output logic [N_LINES-1:0] cfg_dir,
   output logic [N_LINES-1:0] cfg_en,
   output logic [N_LINES-1:0] cfg_mask,
   output logic [N_LINES-1:0] cfg_type,
   output logic [N_LINES-1:0] cfg_pol,
   output logic [N_LINES-1:0] ack_vec
);

   localparam int HI_W = ADDR_W - WORD_MSB - 1;

   logic                   in_window;
   gpio_word_e             word;
   logic [N_LINES-1:0]     wr_bits;
   logic [N_LINES-1:0]     rd_bits;

   assign in_window = (reg_addr[ADDR_W-1:WORD_MSB+1] == HI_W'(0));
   assign word      = gpio_word_e'(reg_addr[WORD_MSB:WORD_LSB]);
   assign wr_bits   = reg_wdata[N_LINES-1:0];

   function automatic logic hit(input logic win, input gpio_word_e w,
                                input gpio_word_e target);
      return win && (w == target);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_dout <= '0;
         cfg_dir  <= '0;
         cfg_en   <= '0;
         cfg_mask <= '0;
         cfg_type <= '0;
         cfg_pol  <= '0;
      end else if (reg_wr) begin
         if (hit(in_window, word, W_DOUT))  cfg_dout <= wr_bits;
         if (hit(in_window, word, W_DIR))   cfg_dir  <= wr_bits;
         if (hit(in_window, word, W_IEN))   cfg_en   <= wr_bits;
         if (hit(in_window, word, W_IMASK)) cfg_mask <= wr_bits;
         if (hit(in_window, word, W_ITYPE)) cfg_type <= wr_bits;
         if (hit(in_window, word, W_IPOL))  cfg_pol  <= wr_bits;
      end
   end

   assign ack_vec = (reg_wr && hit(in_window, word, W_IACK)) ? wr_bits : '0;

   always_comb begin
      rd_bits = '0;
      if (in_window) begin
         case (word)
            W_DOUT:  rd_bits = cfg_dout;
            W_DIR:   rd_bits = cfg_dir;
            W_PIN:   rd_bits = pin_s;
            W_IEN:   rd_bits = cfg_en;
            W_IMASK: rd_bits = cfg_mask;
            W_ITYPE: rd_bits = cfg_type;
            W_IPOL:  rd_bits = cfg_pol;
            W_ISTAT: rd_bits = irq_status;
            default: rd_bits = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= DATA_W'(rd_bits);
   end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
   parameter int N_LINES     = 6,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               reg_rd,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [N_LINES-1:0] pad_in,
   output logic [N_LINES-1:0] pad_out,
   output logic [N_LINES-1:0] pad_oe,
   output logic               irq
);

   if (N_LINES < 1 || N_LINES > DATA_W) begin : g_bad_lines
      initial $fatal(1, "gpio_irq_ctrl: N_LINES out of range");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      initial $fatal(1, "gpio_irq_ctrl: ADDR_W must be at least 7");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $fatal(1, "gpio_irq_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [N_LINES-1:0] pin_s;
   logic [N_LINES-1:0] cfg_dout, cfg_dir, cfg_en, cfg_mask, cfg_type, cfg_pol;
   logic [N_LINES-1:0] ack_vec;
   logic [N_LINES-1:0] line_evt, line_latch, line_status;

   gpio_sync_chain #(
      .WIDTH  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pad_in),
      .q_sync  (pin_s)
   );

   gpio_regfile #(
      .N_LINES (N_LINES),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_addr   (reg_addr),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .reg_rd     (reg_rd),
      .reg_rdata  (reg_rdata),
      .pin_s      (pin_s),
      .irq_status (line_status),
      .cfg_dout   (cfg_dout),
      .cfg_dir    (cfg_dir),
      .cfg_en     (cfg_en),
      .cfg_mask   (cfg_mask),
      .cfg_type   (cfg_type),
      .cfg_pol    (cfg_pol),
      .ack_vec    (ack_vec)
   );

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      gpio_line_irq i_line (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_s     (pin_s[i]),
         .edge_mode (cfg_type[i]),
         .pol_high  (cfg_pol[i]),
         .enable    (cfg_en[i]),
         .mask      (cfg_mask[i]),
         .ack       (ack_vec[i]),
         .edge_evt  (line_evt[i]),
         .latched   (line_latch[i]),
         .status    (line_status[i])
      );
   end

   assign pad_out = cfg_dout;
   assign pad_oe  = cfg_dir;
   assign irq     = |line_status;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
   import gpio_irq_pkg::*;
#(
   parameter int N_LINES = 6,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic               reg_wr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic [N_LINES-1:0] pad_out,
   input logic [N_LINES-1:0] pad_oe,
   input logic               irq,
   input logic [N_LINES-1:0] latch_q,
   input logic [N_LINES-1:0] evt,
   input logic [N_LINES-1:0] en_q,
   input logic [N_LINES-1:0] mask_q
);

   logic wr_dir, wr_dout, wr_ack;
   assign wr_dir  = reg_wr && (reg_addr == ADDR_W'(byte_addr(W_DIR)));
   assign wr_dout = reg_wr && (reg_addr == ADDR_W'(byte_addr(W_DOUT)));
   assign wr_ack  = reg_wr && (reg_addr == ADDR_W'(byte_addr(W_IACK)));

   a_r2_dir_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> pad_oe == $past(reg_wdata[N_LINES-1:0]));

   a_r2_dout_drives_pad: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dout |=> pad_out == $past(reg_wdata[N_LINES-1:0]));

   a_r6_ack_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |=> (latch_q & $past(reg_wdata[N_LINES-1:0] & ~evt)) == '0);

   a_r5_latch_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (latch_q & ~$past(latch_q) & ~$past(evt)) == '0);

   a_r8_disabled_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (latch_q & ~$past(latch_q) & ~$past(en_q)) == '0);

   a_r9_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !irq);

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(
   .N_LINES (N_LINES),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .irq       (irq),
   .latch_q   (line_latch),
   .evt       (line_evt),
   .en_q      (cfg_en),
   .mask_q    (cfg_mask)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;

   localparam logic [7:0] A_DOUT = 8'h00, A_DIR = 8'h04, A_PIN = 8'h08,
                          A_IEN = 8'h0C, A_IMASK = 8'h10, A_ITYPE = 8'h14,
                          A_IPOL = 8'h18, A_ISTAT = 8'h1C, A_IACK = 8'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_rdata;
   logic [5:0]  pad_in = '0;
   logic [5:0]  pad_out, pad_oe;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   gpio_irq_ctrl i_gpio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   // ---------------- behavioural reference model ----------------
   bit [5:0] m_s1, m_s2, m_prev, m_latch;
   bit [5:0] m_dout, m_dir, m_en, m_mask, m_type, m_pol;
   bit [31:0] m_rdata;
   string    m_rtag = "R1";

   function automatic bit [5:0] m_status();
      bit [5:0] r;
      for (int i = 0; i < 6; i++) begin
         bit pend;
         if (m_type[i]) pend = m_latch[i];
         else           pend = (m_s2[i] == m_pol[i]);
         r[i] = pend && m_en[i] && !m_mask[i];
      end
      return r;
   endfunction

   function automatic string tag_of(logic [7:0] a);
      case (a)
         A_DOUT, A_DIR: return "R2";
         A_PIN:   return "R3";
         A_IEN:   return "R8";
         A_IMASK: return "R9";
         A_ITYPE, A_IPOL: return "R4";
         A_ISTAT: return "R10";
         A_IACK:  return "R6";
         default: return "R13";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_latch = 0;
         m_dout = 0; m_dir = 0; m_en = 0; m_mask = 0; m_type = 0; m_pol = 0;
         m_rdata = 0;
      end else begin
         bit [5:0] ack;
         ack = (reg_wr && reg_addr == A_IACK) ? reg_wdata[5:0] : 6'd0;
         if (reg_rd) begin
            m_rtag = tag_of(reg_addr);
            case (reg_addr)
               A_DOUT:  m_rdata = {26'd0, m_dout};
               A_DIR:   m_rdata = {26'd0, m_dir};
               A_PIN:   m_rdata = {26'd0, m_s2};
               A_IEN:   m_rdata = {26'd0, m_en};
               A_IMASK: m_rdata = {26'd0, m_mask};
               A_ITYPE: m_rdata = {26'd0, m_type};
               A_IPOL:  m_rdata = {26'd0, m_pol};
               A_ISTAT: m_rdata = {26'd0, m_status()};
               default: m_rdata = 0;
            endcase
         end
         for (int i = 0; i < 6; i++) begin
            bit ev;
            ev = m_type[i] && m_en[i] &&
                 (m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]));
            if (!m_type[i])  m_latch[i] = 0;
            else if (ev)     m_latch[i] = 1;
            else if (ack[i]) m_latch[i] = 0;
         end
         if (reg_wr) begin
            case (reg_addr)
               A_DOUT:  m_dout = reg_wdata[5:0];
               A_DIR:   m_dir  = reg_wdata[5:0];
               A_IEN:   m_en   = reg_wdata[5:0];
               A_IMASK: m_mask = reg_wdata[5:0];
               A_ITYPE: m_type = reg_wdata[5:0];
               A_IPOL:  m_pol  = reg_wdata[5:0];
               default: ;
            endcase
         end
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = pad_in;
      end
   end

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=0x%0h exp=0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R10", "irq vs model", {31'd0, irq}, {31'd0, |m_status()});
         chk("R2", "pad_out vs model", {26'd0, pad_out}, {26'd0, m_dout});
         chk("R2", "pad_oe vs model", {26'd0, pad_oe}, {26'd0, m_dir});
         chk(m_rtag, "rdata vs model", reg_rdata, m_rdata);
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] v);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1;
      @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
   endtask

   task automatic expect_reg(string tag, logic [7:0] a, logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, $sformatf("read 0x%02h", a), v, exp);
   endtask

   task automatic pins(logic [5:0] v);
      @(negedge clk); pad_in = v;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL R1 watchdog act=hung exp=finished");
         report();
      end
   end

   initial begin
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
      chk("R1", "pad_oe after reset", {26'd0, pad_oe}, 32'd0);
      for (int a = 0; a <= 8; a++) expect_reg("R1", 8'(a * 4), 32'd0);

      // R2 direction and output data
      wr(A_DOUT, 32'h2A);
      wr(A_DIR, 32'h15);
      expect_reg("R2", A_DOUT, 32'h2A);
      expect_reg("R2", A_DIR, 32'h15);
      chk("R2", "pad_out", {26'd0, pad_out}, 32'h2A);
      chk("R2", "pad_oe", {26'd0, pad_oe}, 32'h15);
      wr(A_DOUT, 32'hFFFF_FFFF);
      expect_reg("R2", A_DOUT, 32'h3F);

      // R3 pin level, write ignored
      pins(6'h2D); idle(3);
      expect_reg("R3", A_PIN, 32'h2D);
      wr(A_PIN, 32'h0);
      expect_reg("R3", A_PIN, 32'h2D);
      pins(6'h00); idle(4);

      // edge setup: lines 0,1 edge; pol line0/2 high, line1/3 low
      wr(A_ITYPE, 32'h03);
      wr(A_IPOL, 32'h05);
      // R8 edge while disabled is not latched
      pins(6'h01); idle(4);
      expect_reg("R8", A_ISTAT, 32'h0);
      wr(A_IEN, 32'h01);
      expect_reg("R8", A_ISTAT, 32'h0);
      // R5 rising edge latched and held
      pins(6'h00); idle(4);
      pins(6'h01); idle(4);
      expect_reg("R5", A_ISTAT, 32'h01);
      chk("R10", "irq on latched edge", {31'd0, irq}, 32'd1);
      pins(6'h00); idle(4);
      expect_reg("R5", A_ISTAT, 32'h01);
      // R6 zeros do nothing, ones clear
      wr(A_IACK, 32'h3E);
      expect_reg("R6", A_ISTAT, 32'h01);
      wr(A_IACK, 32'h01);
      expect_reg("R6", A_ISTAT, 32'h0);
      expect_reg("R6", A_IACK, 32'h0);

      // R5 falling edge on line 1
      wr(A_IEN, 32'h03);
      pins(6'h02); idle(4);
      expect_reg("R5", A_ISTAT, 32'h0);
      pins(6'h00); idle(4);
      expect_reg("R5", A_ISTAT, 32'h02);
      wr(A_IACK, 32'h02);

      // R9 mask hides but keeps the latch
      wr(A_IMASK, 32'h01);
      pins(6'h01); idle(4);
      expect_reg("R9", A_ISTAT, 32'h0);
      chk("R9", "irq while masked", {31'd0, irq}, 32'd0);
      wr(A_IMASK, 32'h00);
      expect_reg("R9", A_ISTAT, 32'h01);
      chk("R9", "irq after unmask", {31'd0, irq}, 32'd1);
      wr(A_IACK, 32'h01);
      pins(6'h00); idle(4);

      // R4 level active-high on line 2, R7 ack has no effect
      wr(A_IEN, 32'h07);
      expect_reg("R4", A_ISTAT, 32'h0);
      pins(6'h04); idle(3);
      expect_reg("R4", A_ISTAT, 32'h04);
      wr(A_IACK, 32'h04);
      expect_reg("R7", A_ISTAT, 32'h04);
      pins(6'h00); idle(3);
      expect_reg("R4", A_ISTAT, 32'h0);
      // R4 level active-low on line 3
      wr(A_IEN, 32'h0F);
      expect_reg("R4", A_ISTAT, 32'h08);
      pins(6'h08); idle(3);
      expect_reg("R4", A_ISTAT, 32'h0);
      wr(A_IEN, 32'h07);
      pins(6'h00); idle(4);

      // R11 polarity flip on a steady pin
      pins(6'h01); idle(4);
      expect_reg("R11", A_ISTAT, 32'h01);
      wr(A_IACK, 32'h01);
      wr(A_IPOL, 32'h04); idle(4);
      expect_reg("R11", A_ISTAT, 32'h0);
      wr(A_IPOL, 32'h05); idle(4);
      expect_reg("R11", A_ISTAT, 32'h0);
      pins(6'h00); idle(4);
      expect_reg("R11", A_ISTAT, 32'h0);

      // R12 leaving edge mode discards the latch
      pins(6'h01); idle(4);
      pins(6'h00); idle(4);
      expect_reg("R12", A_ISTAT, 32'h01);
      wr(A_ITYPE, 32'h02);
      expect_reg("R12", A_ISTAT, 32'h0);
      wr(A_ITYPE, 32'h03);
      expect_reg("R12", A_ISTAT, 32'h0);

      // R6 event in the same cycle as the clear wins
      pins(6'h01); idle(1);
      wr(A_IACK, 32'h01); idle(2);
      expect_reg("R6", A_ISTAT, 32'h01);
      wr(A_IACK, 32'h01);
      expect_reg("R6", A_ISTAT, 32'h0);

      // R10 two lines at once
      pins(6'h00); idle(4);
      pins(6'h02); idle(4);
      pins(6'h01); idle(4);
      expect_reg("R10", A_ISTAT, 32'h03);
      chk("R10", "irq two lines", {31'd0, irq}, 32'd1);
      wr(A_IACK, 32'h03);
      expect_reg("R10", A_ISTAT, 32'h0);
      chk("R10", "irq cleared", {31'd0, irq}, 32'd0);

      // R13 unmapped reads and hold
      expect_reg("R13", 8'h3C, 32'h0);
      expect_reg("R13", 8'h44, 32'h0);
      expect_reg("R13", A_DIR, 32'h15);
      idle(3);
      chk("R13", "rdata holds", reg_rdata, 32'h15);

      idle(2);
      done = 1;
      report();
   end

endmodule